// File: doc/BRIEF.md
# Error Record Command Register Front End

This block is the software-facing side of an error-record store. It exposes a 16-byte window holding two 64-bit registers: an action register at byte offset 0 and a value register at byte offset 8. Software places an argument in the value register, then writes an action code to the action register. Every side effect comes from that action write. Depending on the code, the block latches an operation type, copies the value register into the record offset or target identifier, loads a status or configuration word into the value register, or executes the latched operation. Reads never change state.

Execution is guarded by a key: the low byte of the value register must hold 0x9C when the execute action arrives. Write, read and clear operations go to a separate record-store engine through a one-cycle start pulse. The block stays busy until the engine returns done with a status code. Dummy-write and end operations finish at once with success. Every finished operation stores the command status and returns the target identifier to all ones.

A small sequencer has three states. IDLE waits for a keyed execute. LAUNCH drives the engine start for one cycle. WAIT holds busy until the engine reports done. The transitions are: IDLE to LAUNCH on a keyed execute of an engine operation, LAUNCH to WAIT unconditionally, and WAIT to IDLE on engine done. A keyed execute of a local or unrecognised operation finishes inside IDLE.

Top module: `errlog_cmd_if`

## Requirements
- R1: Reset state:
  - busy is 0.
  - The action and value registers read 0.
  - The latched operation is 0 (begin-write).
  - The record offset is 0 and the target identifier is all ones.
  - The stored command status is success, encoded 0.
- R2: A 64-bit write (bus_wide=1) to offset 8 replaces the whole value register. A 64-bit read there returns it.
- R3: A 32-bit access (bus_wide=0) selects the upper half when address bit 2 is 1 and the lower half otherwise. A 32-bit write changes only the selected half. A 32-bit read returns the selected half in bits 31:0, with bits 63:32 zero.
- R4: A write reaching the lower half of the action register stores its low 32 bits there, and that data is the action code. A 32-bit write at offset 4 is ignored. Reads have no side effect.
- R5: Action codes 0 (begin-write), 1 (begin-read), 2 (begin-clear), 3 (end) and 11 (begin-dummy-write) become the latched operation, visible on eng_op.
- R6: Action 4 copies value bits OFFS_W-1:0 into the record offset. Action 9 copies the whole value register into the target identifier.
- R7: Action 5 (execute) with value bits 7:0 equal to 0x9C, on a latched write, read or clear operation, raises eng_start for exactly one cycle, in the cycle after the action write. busy is 1 from that cycle until the engine reports done. Action 6 loads busy into the value register.
- R8: When the engine reports done:
  - busy returns to 0 in the next cycle.
  - eng_status becomes the command status, which action 7 loads into the value register.
  - The target identifier becomes all ones.
- R9: Execute with value bits 7:0 not equal to 0x9C has no effect. There is no start, and the status and identifier are unchanged.
- R10: A keyed execute of begin-dummy-write or end produces no start. It sets status success and resets the identifier to all ones.
- R11: The query actions each load the value register:

  | Action | Value register after the action |
  |---|---|
  | 16 | TIME_MAX in bits 63:32, TIME_NOM in bits 31:0 (defaults 100 and 10) |
  | 14 | REC_BYTES |
  | 15 | 0 |
  | 10 | rec_count |
  | 13 | buf_base |

- R12: The following action codes change nothing:
  - 8 and 12.
  - Codes from 17 upward.
  - Any code with nonzero bits 31:8.
- R13: An execute arriving while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| bus_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| bus_rdata | output | 64 | Read data for bus_addr and bus_wide |
| buf_base | input | 64 | Exchange buffer base address returned by action 13 |
| rec_count | input | 32 | Stored record count returned by action 10 |
| eng_start | output | 1 | One-cycle start pulse to the record engine |
| eng_op | output | 8 | Latched operation code |
| eng_id | output | 64 | Target record identifier |
| eng_offset | output | OFFS_W | Record offset within the exchange buffer |
| eng_done | input | 1 | Engine finished the current operation |
| eng_status | input | 8 | Engine completion status, sampled with eng_done |
| busy | output | 1 | An engine operation is in progress |

## Verification
The bench sweeps the half selections of 32-bit access patterns. A design that merged the halves wrongly would corrupt the half it should keep, or return the wrong half on a read. It walks every action code from 0 to 31, plus a code with nonzero upper bits, and checks that the ignored ones leave the value register and the engine outputs alone. Execute is tried with a wrong key, while busy, and on local operations. A design that lost the key check, started twice, or reached the engine for dummy-write or end would show a wrong start count, status or identifier. Completion is checked for the one-cycle busy drop, the captured engine status and the identifier returning to all ones.

// File: rtl/errlog_cmd_pkg.sv
package errlog_cmd_pkg;

    typedef enum logic [7:0] {
        ACT_BEGIN_WR   = 8'h00,
        ACT_BEGIN_RD   = 8'h01,
        ACT_BEGIN_CLR  = 8'h02,
        ACT_END        = 8'h03,
        ACT_SET_OFFS   = 8'h04,
        ACT_EXECUTE    = 8'h05,
        ACT_CHK_BUSY   = 8'h06,
        ACT_GET_STATUS = 8'h07,
        ACT_SET_ID     = 8'h09,
        ACT_GET_COUNT  = 8'h0A,
        ACT_BEGIN_DUMMY= 8'h0B,
        ACT_GET_BASE   = 8'h0D,
        ACT_GET_LEN    = 8'h0E,
        ACT_GET_ATTR   = 8'h0F,
        ACT_GET_TIMING = 8'h10
    } act_e;

    localparam logic [7:0] ST_SUCCESS = 8'h00;
    localparam logic [7:0] ST_FAILED  = 8'h03;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/errlog_half_lane.sv
module errlog_half_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic         wide,
    input  logic         hi,
    output logic [W-1:0] merged,
    output logic [W-1:0] rview
);
    localparam int H = W / 2;

    always_comb begin
        merged = cur;
        if (wide) begin
            merged = wdata;
        end else if (hi) begin
            merged[W-1:H] = wdata[H-1:0];
        end else begin
            merged[H-1:0] = wdata[H-1:0];
        end
    end

    always_comb begin
        rview = '0;
        if (wide) begin
            rview = cur;
        end else if (hi) begin
            rview[H-1:0] = cur[W-1:H];
        end else begin
            rview[H-1:0] = cur[H-1:0];
        end
    end

endmodule

// File: rtl/errlog_exec_seq.sv
module errlog_exec_seq
    import errlog_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exec_req,
    input  logic [7:0] op,
    input  logic       eng_done,
    input  logic [7:0] eng_status,
    output logic       eng_start,
    output logic       busy,
    output logic       fin,
    output logic [7:0] fin_status
);
    seq_state_e state_q, state_d;

    logic op_engine;
    logic op_local;
    assign op_engine = (op == ACT_BEGIN_WR) || (op == ACT_BEGIN_RD) || (op == ACT_BEGIN_CLR);
    assign op_local  = (op == ACT_BEGIN_DUMMY) || (op == ACT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        eng_start  = 1'b0;
        busy       = 1'b0;
        fin        = 1'b0;
        fin_status = ST_SUCCESS;
        unique case (state_q)
            SEQ_IDLE: begin
                if (exec_req) begin
                    if (op_engine) begin
                        state_d = SEQ_LAUNCH;
                    end else begin
                        fin        = 1'b1;
                        fin_status = op_local ? ST_SUCCESS : ST_FAILED;
                    end
                end
            end
            SEQ_LAUNCH: begin
                eng_start = 1'b1;
                busy      = 1'b1;
                state_d   = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                busy = 1'b1;
                if (eng_done) begin
                    fin        = 1'b1;
                    fin_status = eng_status;
                    state_d    = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // R7: start is a single pulse and is followed by the wait phase
    assert_start_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (busy && !eng_start));

    // R8: engine completion ends busy on the next cycle
    assert_done_clears_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start && eng_done) |=> !busy);

endmodule

// File: rtl/errlog_cmd_if.sv
module errlog_cmd_if
    import errlog_cmd_pkg::*;
#(
    parameter int          OFFS_W    = 32,
    parameter int          REC_BYTES = 8192,
    parameter int          TIME_MAX  = 100,
    parameter int          TIME_NOM  = 10,
    parameter logic [7:0]  EXEC_KEY  = 8'h9C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wide,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic [63:0]       buf_base,
    input  logic [31:0]       rec_count,
    output logic              eng_start,
    output logic [7:0]        eng_op,
    output logic [63:0]       eng_id,
    output logic [OFFS_W-1:0] eng_offset,
    input  logic              eng_done,
    input  logic [7:0]        eng_status,
    output logic              busy
);
    localparam int NREG = 2;
    localparam logic [63:0] TIMING_WORD = {32'(TIME_MAX), 32'(TIME_NOM)};
    localparam logic [63:0] LEN_WORD    = 64'(REC_BYTES);

    logic [63:0]       act_q, val_q;
    logic [7:0]        op_q, status_q;
    logic [63:0]       id_q;
    logic [OFFS_W-1:0] offs_q;

    logic [63:0] reg_cur   [NREG];
    logic [63:0] reg_merge [NREG];
    logic [63:0] reg_view  [NREG];

    assign reg_cur[0] = act_q;
    assign reg_cur[1] = val_q;

    for (genvar g = 0; g < NREG; g++) begin : g_lane
        errlog_half_lane #(.W(64)) u_lane (
            .cur   (reg_cur[g]),
            .wdata (bus_wdata),
            .wide  (bus_wide),
            .hi    (bus_addr[2]),
            .merged(reg_merge[g]),
            .rview (reg_view[g])
        );
    end

    assign bus_rdata = reg_view[bus_addr[3]];

    logic       act_wr, val_wr, code_ok, exec_wr, exec_req;
    logic [7:0] code;
    logic       fin;
    logic [7:0] fin_status;

    assign act_wr   = bus_wr && !bus_addr[3] && (bus_wide || !bus_addr[2]);
    assign val_wr   = bus_wr && bus_addr[3];
    assign code     = bus_wdata[7:0];
    assign code_ok  = (bus_wdata[31:8] == 24'd0);
    assign exec_wr  = act_wr && code_ok && (code == ACT_EXECUTE);
    assign exec_req = exec_wr && (val_q[7:0] == EXEC_KEY);

    errlog_exec_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_req  (exec_req),
        .op        (op_q),
        .eng_done  (eng_done),
        .eng_status(eng_status),
        .eng_start (eng_start),
        .busy      (busy),
        .fin       (fin),
        .fin_status(fin_status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= '0;
            val_q    <= '0;
            op_q     <= ACT_BEGIN_WR;
            status_q <= ST_SUCCESS;
            id_q     <= '1;
            offs_q   <= '0;
        end else begin
            if (val_wr) val_q <= reg_merge[1];
            if (act_wr) begin
                act_q <= {32'd0, bus_wdata[31:0]};
                if (code_ok) begin
                    unique case (code)
                        ACT_BEGIN_WR, ACT_BEGIN_RD, ACT_BEGIN_CLR,
                        ACT_END, ACT_BEGIN_DUMMY: op_q <= code;
                        ACT_SET_OFFS:   offs_q <= val_q[OFFS_W-1:0];
                        ACT_SET_ID:     id_q   <= val_q;
                        ACT_CHK_BUSY:   val_q  <= {63'd0, busy};
                        ACT_GET_STATUS: val_q  <= {56'd0, status_q};
                        ACT_GET_COUNT:  val_q  <= {32'd0, rec_count};
                        ACT_GET_BASE:   val_q  <= buf_base;
                        ACT_GET_LEN:    val_q  <= LEN_WORD;
                        ACT_GET_ATTR:   val_q  <= '0;
                        ACT_GET_TIMING: val_q  <= TIMING_WORD;
                        default: ;
                    endcase
                end
            end
            if (fin) begin
                status_q <= fin_status;
                id_q     <= '1;
            end
        end
    end

    assign eng_op     = op_q;
    assign eng_id     = id_q;
    assign eng_offset = offs_q;

    // R9: a start only follows an execute that saw the key
    assert_start_keyed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ($past(val_q[7:0]) == EXEC_KEY));

    // R8: when busy drops, the identifier has been returned to all ones
    assert_id_reset_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (eng_id == '1));

    // R4: a 32-bit write at the upper action half leaves the action register alone
    assert_upper_action_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[3:2] == 2'b01) && !bus_wide) |=> $stable(act_q));

    // R13: execute during busy never produces a start
    assert_no_restart_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && exec_wr) |=> !eng_start);

endmodule

// File: tb/errlog_cmd_if_tb.sv
module errlog_cmd_if_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wide = 1'b1;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] buf_base = 64'h0000_00F0_ABCD_0000;
    logic [31:0] rec_count = 32'd17;
    logic        eng_start;
    logic [7:0]  eng_op;
    logic [63:0] eng_id;
    logic [31:0] eng_offset;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int n_start = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errlog_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .buf_base(buf_base), .rec_count(rec_count), .eng_start(eng_start),
        .eng_op(eng_op), .eng_id(eng_id), .eng_offset(eng_offset),
        .eng_done(eng_done), .eng_status(eng_status), .busy(busy)
    );

    always @(negedge clk) if (rst_n && eng_start) n_start++;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic w, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wide = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic w, output logic [63:0] d);
        bus_addr = a; bus_wide = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic act(input logic [63:0] code);
        wr(4'h0, 1'b1, code);
    endtask

    function automatic logic [31:0] pat(input int i, input int salt);
        return 32'(i * 32'h1357_9BDF + salt * 32'h0246_8ACE + 32'h1111_0000);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] r, v, exp_val;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {63'd0, busy}, 64'd0);
        rd(4'h8, 1'b1, r); chk("R1 value", r, 64'd0);
        rd(4'h0, 1'b1, r); chk("R1 action", r, 64'd0);
        chk("R1 op", {56'd0, eng_op}, 64'd0);
        chk("R1 offset", {32'd0, eng_offset}, 64'd0);
        chk("R1 id", eng_id, '1);
        act(64'd7); rd(4'h8, 1'b1, r); chk("R1 status success", r, 64'd0);

        // R2 full-width value access
        for (int i = 0; i < 4; i++) begin
            v = {pat(i, 3), pat(i, 5)};
            wr(4'h8, 1'b1, v);
            rd(4'h8, 1'b1, r); chk("R2 wide rw", r, v);
        end

        // R3 half sweep
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lo, hi;
            lo = pat(i, 1); hi = pat(i, 2);
            wr(4'h8, 1'b0, {32'hFFFF_FFFF, lo});
            wr(4'hC, 1'b0, {32'hFFFF_FFFF, hi});
            rd(4'h8, 1'b1, r); chk("R3 halves merged", r, {hi, lo});
            rd(4'h8, 1'b0, r); chk("R3 read low", r, {32'd0, lo});
            rd(4'hC, 1'b0, r); chk("R3 read high", r, {32'd0, hi});
            wr(4'h8, 1'b0, {32'd0, ~lo});
            rd(4'h8, 1'b1, r); chk("R3 high kept", r, {hi, ~lo});
        end

        // R4 action register
        act(64'hDEAD_BEEF_0000_0013);
        rd(4'h0, 1'b1, r); chk("R4 action low stored", r, 64'h13);
        wr(4'h4, 1'b0, 64'h3);
        rd(4'h0, 1'b1, r); chk("R4 upper write ignored", r, 64'h13);
        chk("R4 op unchanged", {56'd0, eng_op}, 64'd0);
        rd(4'h4, 1'b0, r); rd(4'h0, 1'b0, r);
        chk("R4 read low half", r, 64'h13);

        // R5 latching
        foreach (r[k]) if (k < 1) ;
        begin
            logic [7:0] codes [5] = '{8'h1, 8'h2, 8'h3, 8'hB, 8'h0};
            for (int i = 0; i < 5; i++) begin
                act({56'd0, codes[i]});
                chk("R5 op latched", {56'd0, eng_op}, {56'd0, codes[i]});
            end
        end

        // R6 parameter copies
        wr(4'h8, 1'b1, 64'h1234_5678_9ABC_DEF0);
        act(64'd4); chk("R6 offset", {32'd0, eng_offset}, 64'h9ABC_DEF0);
        act(64'd9); chk("R6 id", eng_id, 64'h1234_5678_9ABC_DEF0);

        // R11 queries
        act(64'h10); rd(4'h8, 1'b1, r); chk("R11 timing", r, {32'd100, 32'd10});
        act(64'h0E); rd(4'h8, 1'b1, r); chk("R11 length", r, 64'd8192);
        act(64'h0F); rd(4'h8, 1'b1, r); chk("R11 attr", r, 64'd0);
        act(64'h0A); rd(4'h8, 1'b1, r); chk("R11 count", r, 64'd17);
        act(64'h0D); rd(4'h8, 1'b1, r); chk("R11 base", r, buf_base);

        // R9 wrong key
        act(64'd1);
        wr(4'h8, 1'b1, 64'h55);
        act(64'd9);
        wr(4'h8, 1'b1, 64'h19D);
        act(64'd5);
        @(negedge clk);
        chk("R9 no start", 64'(n_start), 64'd0);
        chk("R9 id kept", eng_id, 64'h55);
        act(64'd7); rd(4'h8, 1'b1, r); chk("R9 status kept", r, 64'd0);

        // R7 / R8 / R13 engine run
        wr(4'h8, 1'b1, 64'hAB9C);
        act(64'd5);
        chk("R7 start pulse", {63'd0, eng_start}, 64'd1);
        chk("R7 busy", {63'd0, busy}, 64'd1);
        act(64'd6);
        chk("R7 start single", {63'd0, eng_start}, 64'd0);
        rd(4'h8, 1'b1, r); chk("R7 check busy", r, 64'd1);
        wr(4'h8, 1'b1, 64'h9C);
        act(64'd5);
        @(negedge clk);
        chk("R13 no restart", 64'(n_start), 64'd1);
        chk("R7 still busy", {63'd0, busy}, 64'd1);
        eng_status = 8'h05; eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R8 busy cleared", {63'd0, busy}, 64'd0);
        chk("R8 id ones", eng_id, '1);
        act(64'd7); rd(4'h8, 1'b1, r); chk("R8 status captured", r, 64'd5);
        act(64'd6); rd(4'h8, 1'b1, r); chk("R7 idle busy", r, 64'd0);

        // R10 local operations
        for (int i = 0; i < 2; i++) begin
            act(i == 0 ? 64'hB : 64'h3);
            wr(4'h8, 1'b1, 64'h77);
            act(64'd9);
            wr(4'h8, 1'b1, 64'h9C);
            act(64'd5);
            chk("R10 no busy", {63'd0, busy}, 64'd0);
            chk("R10 id ones", eng_id, '1);
            act(64'd7); rd(4'h8, 1'b1, r); chk("R10 status success", r, 64'd0);
        end
        chk("R10 no engine start", 64'(n_start), 64'd1);

        // R12 unknown codes
        act(64'd2);
        wr(4'h8, 1'b1, 64'h0BAD_F00D_0000_009C);
        act(64'd4); act(64'd9);
        for (int c = 0; c < 33; c++) begin
            logic [63:0] code;
            code = (c == 32) ? 64'h105 : 64'(c);
            if (c == 8 || c == 12 || c >= 17) begin
                act(code);
                @(negedge clk);
                rd(4'h8, 1'b1, r); chk("R12 value kept", r, 64'h0BAD_F00D_0000_009C);
                chk("R12 op kept", {56'd0, eng_op}, 64'd2);
                chk("R12 id kept", eng_id, 64'h0BAD_F00D_0000_009C);
                chk("R12 offset kept", {32'd0, eng_offset}, 64'h9C);
                chk("R12 no start", 64'(n_start), 64'd1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule